// File: doc/BRIEF.md
# Receive Frame Buffer with Frame Skip

This block sits between a network receive MAC and a host bus. Frames arrive one 32-bit word at a time on a MAC-side write port, each word with an end-of-frame marker. They land first in a small staging FIFO of fixed size, 128 bytes by default. A frame becomes eligible to move on only once its final word has been written. Complete frames then drain, one word per cycle, into a larger host data FIFO whenever that FIFO has room. The host pops words from the data FIFO and receives each one with its end-of-frame tag.

The host can abandon the frame at the head of the data FIFO by writing a control word with bit 31 set. A skip engine then discards entries through the next end-of-frame tag. The busy bit reads back as 1 until the skip is done. While the data FIFO is full, words pile up in the staging FIFO. If the staging FIFO overruns, the frame being written is removed completely and the rest of it is ignored. A saturating counter, cleared when the host reads it, records each lost frame.

Top module: `rx_skip_buffer`

## Requirements
- R1: After reset, `ctl_rdata` is zero, `drop_count` is zero, `data_empty` is 1, `data_full` is 0 and `rd_valid` is 0.
- R2: Words leave the host port in arrival order. A pop (`rd_en` while the data FIFO is not empty and no skip is running) gives `rd_valid`=1 with that word's `rd_data` and `rd_last` on the next cycle.
- R3: No word of a frame reaches the data FIFO before that frame's final word (`mac_last`=1) has been written. `data_empty` stays 1 while only part of a frame has arrived.
- R4: The staging FIFO holds `STAGE_WORDS` words (32 words = 128 bytes by default). While the data FIFO is full, it accepts up to that many words without losing a frame.
- R5: When a word arrives while the staging FIFO is full, the words already stored from that frame are removed and its remaining words up to `mac_last` are ignored. The frame never reaches the host, and `drop_count` rises by exactly one for that frame.
- R6: `drop_count` stops at its maximum (2^`DROP_W`-1). A cycle with `drop_rd`=1 shows the current value and leaves the counter at 0, or at 1 when a frame is lost in that same cycle.
- R7: A control write with bit 31 set starts a skip. `ctl_rdata` bit 31 reads 1 from the next cycle until the skip ends, and bits 30:0 always read 0. A control write with bit 31 clear has no effect.
- R8: A skip discards data-FIFO entries up to and including the next entry tagged end-of-frame, then clears bit 31. The next host pop returns the first word of the following frame.
- R9: When the data FIFO holds no end-of-frame entry, the skip stays busy until such an entry arrives, and it discards every word that arrives before it.
- R10: `rd_en` while a skip is running gives `rd_err`=1, `rd_data`=0 and `rd_valid`=0 on the next cycle, and no word is removed.
- R11: `rd_en` while the data FIFO is empty and no skip is running gives `rd_valid`=0 and `rd_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_valid | input | 1 | MAC word strobe |
| mac_data | input | 32 | MAC word |
| mac_last | input | 1 | Final word of the frame |
| rd_en | input | 1 | Host pop request |
| rd_valid | output | 1 | Host word valid, one cycle after the pop |
| rd_data | output | 32 | Host word |
| rd_last | output | 1 | End-of-frame tag of the host word |
| rd_err | output | 1 | Pop was refused because a skip is running |
| data_empty | output | 1 | Data FIFO holds no word |
| data_full | output | 1 | Data FIFO holds DATA_WORDS words |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data; bit 31 starts a skip |
| ctl_rdata | output | 32 | Control readback; bit 31 is the skip-busy flag |
| drop_rd | input | 1 | Host read of the drop counter; clears it |
| drop_count | output | DROP_W | Number of lost frames, saturating |

## Verification
Two events can land on the same clock edge: a frame lost to staging overflow and a host read that clears the drop counter. The bench forces this by first filling both FIFOs and then driving `drop_rd` in the very cycle that carries the overflowing word. It checks that the read shows the old count and that the counter then holds 1, not 0. A second overlap happens when the drain pushes into the data FIFO in the same cycle that the skip engine pops from it. The bench provokes this by starting a skip on an empty data FIFO and then sending a frame, and it judges the result by whether the first word of the next frame comes out.

// File: rtl/rx_skip_pkg.sv
package rx_skip_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic              last;
    logic [WORD_W-1:0] data;
  } rxs_entry_t;
endpackage

// File: rtl/rxs_stage_fifo.sv
module rxs_stage_fifo
  import rx_skip_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  rxs_entry_t in_entry,
  output logic       out_valid,
  output rxs_entry_t out_entry,
  input  logic       out_pop,
  output logic       drop_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  rxs_entry_t  mem [DEPTH];
  logic [AW:0] rd_p, cmt_p, wr_p;
  logic [AW:0] used;
  logic        full;
  logic        dropping;
  logic        store;

  assign used       = wr_p - rd_p;
  assign full       = (used == FULL_LVL);
  assign drop_pulse = in_valid && !dropping && full;
  assign store      = in_valid && !dropping && !full;
  assign out_valid  = (cmt_p != rd_p);
  assign out_entry  = mem[rd_p[AW-1:0]];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (store) mem[wr_p[AW-1:0]] <= in_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p     <= '0;
      cmt_p    <= '0;
      wr_p     <= '0;
      dropping <= 1'b0;
    end else begin
      if (out_pop) rd_p <= rd_p + 1'b1;
      if (in_valid) begin
        if (dropping) begin
          if (in_entry.last) dropping <= 1'b0;
        end else if (full) begin
          wr_p <= cmt_p;                       // roll back the partial frame
          if (!in_entry.last) dropping <= 1'b1;
        end else begin
          wr_p <= wr_p + 1'b1;
          if (in_entry.last) cmt_p <= wr_p + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxs_data_fifo.sv
module rxs_data_fifo
  import rx_skip_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  rxs_entry_t        push_entry,
  output logic              full,
  output logic              empty,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_last,
  output logic              rd_err,
  input  logic              skip_req,
  output logic              skip_busy
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [WORD_W-1:0] dmem [DEPTH];
  logic [DEPTH-1:0]  tags;
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       count;
  logic              host_pop, skip_pop, pop;
  logic              head_last;

  assign empty     = (count == '0);
  assign full      = (count == FULL_LVL);
  assign head_last = tags[rp];
  assign host_pop  = rd_en && !skip_busy && !empty;
  assign skip_pop  = skip_busy && !empty;
  assign pop       = host_pop || skip_pop;

  always_ff @(posedge clk) begin
    if (push) dmem[wp] <= push_entry.data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tags <= '0;
    end else if (push) begin
      tags[wp] <= push_entry.last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // skip engine: discard head entries through the next end-of-frame tag
  always_ff @(posedge clk) begin
    if (rst) begin
      skip_busy <= 1'b0;
    end else if (skip_pop && head_last) begin
      skip_busy <= 1'b0;
    end else if (skip_req) begin
      skip_busy <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= host_pop;
      rd_err   <= rd_en && skip_busy;
      if (host_pop) rd_last <= head_last;
      else if (rd_en && skip_busy) rd_last <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (host_pop) rd_data <= dmem[rp];
    else if (rd_en && skip_busy) rd_data <= '0;
  end
endmodule

// File: rtl/rxs_drop_ctr.sv
module rxs_drop_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX_V = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      count <= inc ? W'(1) : '0;
    end else if (inc && count != MAX_V) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rx_skip_buffer.sv
module rx_skip_buffer
  import rx_skip_pkg::*;
#(
  parameter int STAGE_WORDS = 32,
  parameter int DATA_WORDS  = 512,
  parameter int DROP_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mac_valid,
  input  logic [31:0]       mac_data,
  input  logic              mac_last,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              rd_last,
  output logic              rd_err,
  output logic              data_empty,
  output logic              data_full,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic              drop_rd,
  output logic [DROP_W-1:0] drop_count
);
  localparam int SKIP_BIT = 31;

  rxs_entry_t in_entry, stg_entry;
  logic       stg_valid, xfer, drop_pulse, skip_req, skip_busy;

  assign in_entry.data = mac_data;
  assign in_entry.last = mac_last;
  assign xfer          = stg_valid && !data_full;
  assign skip_req      = ctl_wr && ctl_wdata[SKIP_BIT];
  assign ctl_rdata     = {skip_busy, 31'b0};

  rxs_stage_fifo #(.DEPTH(STAGE_WORDS)) u_stage (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (mac_valid),
    .in_entry   (in_entry),
    .out_valid  (stg_valid),
    .out_entry  (stg_entry),
    .out_pop    (xfer),
    .drop_pulse (drop_pulse)
  );

  rxs_data_fifo #(.DEPTH(DATA_WORDS)) u_data (
    .clk        (clk),
    .rst        (rst),
    .push       (xfer),
    .push_entry (stg_entry),
    .full       (data_full),
    .empty      (data_empty),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_last    (rd_last),
    .rd_err     (rd_err),
    .skip_req   (skip_req),
    .skip_busy  (skip_busy)
  );

  rxs_drop_ctr #(.W(DROP_W)) u_drop (
    .clk   (clk),
    .rst   (rst),
    .inc   (drop_pulse),
    .clr   (drop_rd),
    .count (drop_count)
  );
endmodule

// File: rtl/rx_skip_buffer_chk.sv
module rx_skip_buffer_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              rd_err,
  input logic              data_empty,
  input logic              data_full,
  input logic              ctl_wr,
  input logic [31:0]       ctl_wdata,
  input logic [31:0]       ctl_rdata,
  input logic              drop_rd,
  input logic [DROP_W-1:0] drop_count
);
  a_r10_busy_read_err: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ctl_rdata[31]) |=> (rd_err && !rd_valid && rd_data == 32'd0));

  a_r2_pop_valid: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !ctl_rdata[31] && !data_empty) |=> rd_valid);

  a_r11_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !ctl_rdata[31] && data_empty) |=> (!rd_valid && !rd_err));

  a_r7_skip_start: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[31]) |=> ctl_rdata[31]);

  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    drop_rd |=> (drop_count <= DROP_W'(1)));

  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    !drop_rd |=> (drop_count == $past(drop_count) ||
                  drop_count == $past(drop_count) + 1'b1));

  a_r4_full_not_empty: assert property (@(posedge clk) disable iff (rst)
    !(data_full && data_empty));
endmodule

bind rx_skip_buffer rx_skip_buffer_chk #(.DROP_W(DROP_W)) u_chk (.*);

// File: tb/rx_skip_buffer_tb.sv
module rx_skip_buffer_tb;
  localparam int CLK_P = 10;
  localparam int SW = 8;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic mac_valid = 0, mac_last = 0, rd_en = 0, ctl_wr = 0, drop_rd = 0;
  logic [31:0] mac_data = '0, ctl_wdata = '0;
  logic rd_valid, rd_last, rd_err, data_empty, data_full;
  logic [31:0] rd_data, ctl_rdata;
  logic [CW-1:0] drop_count;

  int n_cmp = 0, n_bad = 0;
  logic [32:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  rx_skip_buffer #(.STAGE_WORDS(SW), .DATA_WORDS(DW), .DROP_W(CW)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int id, input int i);
    return 32'((id << 16) | i);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input logic [31:0] d, input logic l);
    mac_valid = 1; mac_data = d; mac_last = l;
    @(negedge clk);
    mac_valid = 0; mac_last = 0;
  endtask

  task automatic frame(input int id, input int len, input bit keep);
    for (int i = 0; i < len; i++) begin
      put(wd(id, i), i == len - 1);
      if (keep) exp_q.push_back({i == len - 1, wd(id, i)});
    end
  endtask

  task automatic read_one(input string req);
    logic [32:0] e;
    e = exp_q.pop_front();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk({req, " valid"}, rd_valid, 1);
    chk({req, " data"}, rd_data, e[31:0]);
    chk({req, " last"}, rd_last, e[32]);
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      idle(2);
      read_one(req);
    end
    idle(4);
    chk({req, " empty after drain"}, data_empty, 1);
  endtask

  task automatic ctl(input logic [31:0] v);
    ctl_wr = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 0; ctl_wdata = '0;
  endtask

  task automatic fill_data();
    for (int f = 0; f < DW / 4; f++) frame(100 + f, 4, 1);
    idle(DW + 4);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 drop", drop_count, 0);
    chk("R1 empty", data_empty, 1);
    chk("R1 full", data_full, 0);
    chk("R1 rd_valid", rd_valid, 0);

    // R11 pop on empty
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R11 valid", rd_valid, 0);
    chk("R11 err", rd_err, 0);

    // R2/R3 sweep over every frame length that fits the staging FIFO
    for (int len = 1; len <= SW; len++) begin
      for (int i = 0; i < len - 1; i++) put(wd(len, i), 0);
      idle(3);
      chk("R3 partial frame held", data_empty, 1);
      put(wd(len, len - 1), 1);
      for (int i = 0; i < len; i++) exp_q.push_back({i == len - 1, wd(len, i)});
      idle(3);
      chk("R3 complete frame moved", data_empty, 0);
      drain("R2");
    end

    // R4 staging accumulates while data FIFO is full; R5 whole-frame drops
    fill_data();
    chk("R4 data full", data_full, 1);
    frame(20, SW, 1);
    idle(4);
    chk("R4 staging held frame", drop_count, 0);
    frame(21, 1, 0);
    chk("R5 drop one", drop_count, 1);
    frame(22, 3, 0);
    chk("R5 drop whole frame once", drop_count, 2);
    drain("R5 survivors");

    // R5 overflow mid-frame rolls back the partial frame
    fill_data();
    frame(30, 5, 1);
    frame(31, 5, 0);
    chk("R5 partial frame dropped", drop_count, 3);
    frame(32, 3, 1);
    chk("R5 next frame kept", drop_count, 3);

    // R6 clear on read
    drop_rd = 1; @(negedge clk); drop_rd = 0;
    chk("R6 cleared", drop_count, 0);
    frame(40, 1, 0);
    frame(41, 1, 0);
    chk("R6 two drops", drop_count, 2);
    // R6 drop and clearing read in the same cycle
    drop_rd = 1;
    chk("R6 read value", drop_count, 2);
    put(wd(42, 0), 1);
    drop_rd = 0;
    chk("R6 same-cycle drop kept", drop_count, 1);
    // R6 saturation sweep
    for (int k = 1; k <= CMAX + 20; k++) begin
      put(wd(43, 0), 1);
      chk("R6 saturate", drop_count, (1 + k > CMAX) ? CMAX : 1 + k);
    end
    drop_rd = 1; @(negedge clk); drop_rd = 0;
    chk("R6 clear after saturation", drop_count, 0);
    drain("R5 rollback survivors");

    // R7 bit 31 clear does nothing, reserved bits read zero
    ctl(32'h7fff_ffff);
    chk("R7 no start", ctl_rdata, 0);

    // R8 skip rest of head frame
    frame(50, 3, 1);
    frame(51, 2, 1);
    frame(52, 4, 1);
    idle(10);
    read_one("R8 first word");
    ctl(32'h8000_0000);
    chk("R7 busy readback", ctl_rdata, 32'h8000_0000);
    void'(exp_q.pop_front());
    void'(exp_q.pop_front());
    idle(5);
    chk("R8 busy cleared", ctl_rdata, 0);
    read_one("R8 next frame");
    drain("R8 rest");

    // R9 skip on empty FIFO waits for a frame; R10 reads refused meanwhile
    ctl(32'h8000_0000);
    idle(10);
    chk("R9 still busy", ctl_rdata[31], 1);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R10 err", rd_err, 1);
    chk("R10 data zero", rd_data, 0);
    chk("R10 no valid", rd_valid, 0);
    frame(60, 3, 0);
    idle(8);
    chk("R9 skip done", ctl_rdata[31], 0);
    chk("R9 frame discarded", data_empty, 1);
    frame(61, 2, 1);
    idle(5);
    drain("R10 no word lost");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule